// File: doc/BRIEF.md
# Stereo Digital Volume with Peak Detect

This block sits in a stereo audio datapath between a sample source and a downstream converter. It takes a left/right pair of 24-bit two's complement samples, qualified by a valid strobe, and scales each channel by its own 8-bit attenuation code. The steps are linear, each worth 1/256 of full scale. A single mute control forces both outputs to zero. The scaled pair appears on the outputs one clock after the sample is accepted, and it holds there until the next valid sample.

Each channel also keeps a peak register that holds the largest input magnitude seen since the last read or reset. A host reads it by pulsing that channel's read strobe, and the read empties the register. Each channel also raises a zero flag once its input has been silent for a long run of samples, so a downstream stage can power down or mute its analog path.

Top module: `stereo_vol_peak`

## Requirements
- R1: One clock after a cycle with `sampleValid` high and `muteEn` low, each channel output equals sample × (256 − code) / 256 with the quotient rounded toward zero (for example −3 at code 128 gives −1), and `outValid` is high for that one cycle.
- R2: Volume code 0 passes the sample through unchanged.
- R3: The left output uses only `volLeft` and the right output uses only `volRight`.
- R4: When `muteEn` is high in a valid cycle, both outputs are zero on the next cycle and `outValid` still pulses.
- R5: Outputs hold their value in every cycle that follows a cycle without `sampleValid`.
- R6: Unless that channel is read, a peak output never decreases. It takes the largest input magnitude that channel has seen since the last read or reset.
- R7: An input of −2^23 is recorded in the peak register as 2^23 − 1.
- R8: A read strobe in a cycle without a valid sample makes that channel's peak output 0 on the next cycle.
- R9: A read strobe in the same cycle as a valid sample loads that sample's magnitude into the peak register, not zero.
- R10: A channel's zero flag goes high in the cycle after its 1024th consecutive zero-valued valid input sample, and not before.
- R11: A channel's zero flag goes low in the cycle after its first non-zero valid input sample.
- R12: After reset, all outputs, peaks and zero flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Qualifies the input sample pair |
| sampleLeft | input | 24 | Left input sample, two's complement |
| sampleRight | input | 24 | Right input sample, two's complement |
| volLeft | input | 8 | Left attenuation code, 0 = unity |
| volRight | input | 8 | Right attenuation code, 0 = unity |
| muteEn | input | 1 | Forces both outputs to zero |
| peakReadLeft | input | 1 | Read-and-clear strobe for the left peak |
| peakReadRight | input | 1 | Read-and-clear strobe for the right peak |
| outLeft | output | 24 | Scaled left sample |
| outRight | output | 24 | Scaled right sample |
| outValid | output | 1 | Pulses with each new output pair |
| peakLeft | output | 23 | Left peak magnitude |
| peakRight | output | 23 | Right peak magnitude |
| zeroLeft | output | 1 | Left silence flag |
| zeroRight | output | 1 | Right silence flag |

## Verification
The zero flags are the hardest behaviour to reach: a flag needs a run of exactly 1024 zero samples on one channel while the other channel carries signal. The bench drives 1023 such pairs and checks that the flag is still low, then sends the 1024th and checks that it rises. Before the run it sends a non-zero sample so the count starts from zero. The coincident read-and-sample case also needs a read strobe aligned to the same edge as a valid pair, and a dedicated task drives that alignment.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int CH_COUNT = 2;

  typedef struct packed {
    logic                sampleLoad;
    logic                muteOut;
    logic [CH_COUNT-1:0] peakLoad;
    logic [CH_COUNT-1:0] peakClear;
  } vol_strobe_t;
endpackage

// File: rtl/vol_ctrl.sv
module vol_ctrl
  import vol_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int ZERO_RUN = 1024
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             sampleValid,
  input  logic                             muteEn,
  input  logic [CH_COUNT-1:0][DATA_W-1:0]  sampleIn,
  input  logic [CH_COUNT-1:0]              peakRead,
  input  logic [CH_COUNT-1:0]              magGreater,
  output vol_strobe_t                      strobes,
  output logic [CH_COUNT-1:0]              zeroFlag
);
  localparam int CNT_W = $clog2(ZERO_RUN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(ZERO_RUN);

  logic [CH_COUNT-1:0][CNT_W-1:0] zeroCount;

  always_comb begin
    strobes.sampleLoad = sampleValid;
    strobes.muteOut    = muteEn;
    for (int c = 0; c < CH_COUNT; c++) begin
      strobes.peakLoad[c]  = sampleValid & (peakRead[c] | magGreater[c]);
      strobes.peakClear[c] = peakRead[c] & ~sampleValid;
    end
  end

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_zero
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        zeroCount[c] <= '0;
      end else if (sampleValid) begin
        if (sampleIn[c] != '0) begin
          zeroCount[c] <= '0;
        end else if (zeroCount[c] != RUN_MAX) begin
          zeroCount[c] <= zeroCount[c] + 1'b1;
        end
      end
    end

    assign zeroFlag[c] = (zeroCount[c] == RUN_MAX);

    // R11: a non-zero sample drops the flag on the next cycle
    assert_zero_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
      (sampleValid && sampleIn[c] != '0) |=> !zeroFlag[c]);

    // R10: the flag can only rise on a zero-valued valid sample
    assert_zero_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
      (!zeroFlag[c] && !(sampleValid && sampleIn[c] == '0)) |=> !zeroFlag[c]);
  end
endmodule

// File: rtl/vol_datapath.sv
module vol_datapath
  import vol_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int VOL_W  = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  vol_strobe_t                      strobes,
  input  logic [CH_COUNT-1:0][DATA_W-1:0]  sampleIn,
  input  logic [CH_COUNT-1:0][VOL_W-1:0]   volCode,
  output logic [CH_COUNT-1:0][DATA_W-1:0]  outSample,
  output logic                             outValid,
  output logic [CH_COUNT-1:0][DATA_W-2:0]  peakMag,
  output logic [CH_COUNT-1:0]              magGreater
);
  localparam int FULL_SCALE = 1 << VOL_W;
  localparam int PROD_W     = DATA_W + VOL_W + 2;
  localparam logic [DATA_W-2:0] MAG_MAX = '1;
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [CH_COUNT-1:0][DATA_W-1:0] scaled;
  logic [CH_COUNT-1:0][DATA_W-2:0] inMag;

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
    logic signed [PROD_W-1:0] gainS;
    logic signed [PROD_W-1:0] product;
    logic signed [PROD_W-1:0] biased;
    logic signed [PROD_W-1:0] shifted;
    logic        [DATA_W-1:0] negated;

    always_comb begin
      gainS   = PROD_W'(FULL_SCALE) - PROD_W'(volCode[c]);
      product = PROD_W'($signed(sampleIn[c])) * gainS;
      biased  = product[PROD_W-1] ? product + PROD_W'(FULL_SCALE - 1) : product;
      shifted = biased >>> VOL_W;
      scaled[c] = shifted[DATA_W-1:0];
    end

    always_comb begin
      negated = -sampleIn[c];
      if (sampleIn[c] == MOST_NEG) begin
        inMag[c] = MAG_MAX;
      end else if (sampleIn[c][DATA_W-1]) begin
        inMag[c] = negated[DATA_W-2:0];
      end else begin
        inMag[c] = sampleIn[c][DATA_W-2:0];
      end
    end

    assign magGreater[c] = (inMag[c] > peakMag[c]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outSample[c] <= '0;
      end else if (strobes.sampleLoad) begin
        outSample[c] <= strobes.muteOut ? '0 : scaled[c];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        peakMag[c] <= '0;
      end else if (strobes.peakLoad[c]) begin
        peakMag[c] <= inMag[c];
      end else if (strobes.peakClear[c]) begin
        peakMag[c] <= '0;
      end
    end

    // R4: a muted sample produces zero
    assert_mute_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.sampleLoad && strobes.muteOut) |=> outSample[c] == '0);

    // R5: no sample, no change at the output
    assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.sampleLoad |=> $stable(outSample[c]));

    // R2: code zero is a pass-through
    assert_unity_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.sampleLoad && !strobes.muteOut && volCode[c] == '0)
        |=> outSample[c] == $past(sampleIn[c]));

    // R7: the most negative code records the largest magnitude
    assert_peak_sat_R7: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.sampleLoad && sampleIn[c] == MOST_NEG) |=> peakMag[c] == MAG_MAX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strobes.sampleLoad;
  end
endmodule

// File: rtl/stereo_vol_peak.sv
module stereo_vol_peak
  import vol_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int VOL_W    = 8,
  parameter int ZERO_RUN = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleLeft,
  input  logic [DATA_W-1:0] sampleRight,
  input  logic [VOL_W-1:0]  volLeft,
  input  logic [VOL_W-1:0]  volRight,
  input  logic              muteEn,
  input  logic              peakReadLeft,
  input  logic              peakReadRight,
  output logic [DATA_W-1:0] outLeft,
  output logic [DATA_W-1:0] outRight,
  output logic              outValid,
  output logic [DATA_W-2:0] peakLeft,
  output logic [DATA_W-2:0] peakRight,
  output logic              zeroLeft,
  output logic              zeroRight
);
  vol_strobe_t                      strobes;
  logic [CH_COUNT-1:0][DATA_W-1:0]  sampleIn;
  logic [CH_COUNT-1:0][VOL_W-1:0]   volCode;
  logic [CH_COUNT-1:0]              peakRead;
  logic [CH_COUNT-1:0]              magGreater;
  logic [CH_COUNT-1:0][DATA_W-1:0]  outSample;
  logic [CH_COUNT-1:0][DATA_W-2:0]  peakMag;
  logic [CH_COUNT-1:0]              zeroFlag;

  assign sampleIn = {sampleRight, sampleLeft};
  assign volCode  = {volRight, volLeft};
  assign peakRead = {peakReadRight, peakReadLeft};

  vol_ctrl #(.DATA_W(DATA_W), .ZERO_RUN(ZERO_RUN)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .muteEn(muteEn),
    .sampleIn(sampleIn), .peakRead(peakRead), .magGreater(magGreater),
    .strobes(strobes), .zeroFlag(zeroFlag)
  );

  vol_datapath #(.DATA_W(DATA_W), .VOL_W(VOL_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sampleIn(sampleIn),
    .volCode(volCode), .outSample(outSample), .outValid(outValid),
    .peakMag(peakMag), .magGreater(magGreater)
  );

  assign outLeft   = outSample[0];
  assign outRight  = outSample[1];
  assign peakLeft  = peakMag[0];
  assign peakRight = peakMag[1];
  assign zeroLeft  = zeroFlag[0];
  assign zeroRight = zeroFlag[1];

  // R6: without a read the peak never falls
  assert_peak_mono_left_R6: assert property (@(posedge clk) disable iff (!rstN)
    !peakReadLeft |=> peakLeft >= $past(peakLeft));
  assert_peak_mono_right_R6: assert property (@(posedge clk) disable iff (!rstN)
    !peakReadRight |=> peakRight >= $past(peakRight));

  // R8: a read with no sample empties the register
  assert_peak_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (peakReadLeft && !sampleValid) |=> peakLeft == '0);

  // R1: output valid follows the input strobe by one cycle
  assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> outValid);
endmodule

// File: tb/tb_stereo_vol_peak.sv
module tb_stereo_vol_peak;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [DW-1:0] sampleLeft = '0, sampleRight = '0;
  logic [7:0] volLeft = '0, volRight = '0;
  logic muteEn = 1'b0, peakReadLeft = 1'b0, peakReadRight = 1'b0;
  logic [DW-1:0] outLeft, outRight;
  logic outValid;
  logic [DW-2:0] peakLeft, peakRight;
  logic zeroLeft, zeroRight;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_vol_peak dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .volLeft(volLeft), .volRight(volRight), .muteEn(muteEn),
    .peakReadLeft(peakReadLeft), .peakReadRight(peakReadRight),
    .outLeft(outLeft), .outRight(outRight), .outValid(outValid),
    .peakLeft(peakLeft), .peakRight(peakRight),
    .zeroLeft(zeroLeft), .zeroRight(zeroRight)
  );

  task automatic check(string req, longint actual, longint expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic longint expScale(longint s, int code);
    longint p = s * (256 - code);
    return p / 256;
  endfunction

  function automatic longint sx(logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  // drive one pair at a falling edge, return at the next falling edge
  task automatic sendPair(longint l, longint r, bit rdL = 0, bit rdR = 0);
    sampleLeft = DW'(l); sampleRight = DW'(r);
    peakReadLeft = rdL; peakReadRight = rdR;
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0; peakReadLeft = 1'b0; peakReadRight = 1'b0;
  endtask

  task automatic readOnly(bit rdL, bit rdR);
    peakReadLeft = rdL; peakReadRight = rdR;
    @(negedge clk);
    peakReadLeft = 1'b0; peakReadRight = 1'b0;
  endtask

  task automatic testReset();
    check("R12 outLeft", sx(outLeft), 0);
    check("R12 outValid", outValid, 0);
    check("R12 peakLeft", peakLeft, 0);
    check("R12 peakRight", peakRight, 0);
    check("R12 zeroLeft", zeroLeft, 0);
  endtask

  task automatic testUnity();
    volLeft = 0; volRight = 0;
    sendPair(1234, -5678);
    check("R2 left unity", sx(outLeft), 1234);
    check("R2 right unity", sx(outRight), -5678);
    check("R1 outValid pulse", outValid, 1);
  endtask

  task automatic testScale();
    volLeft = 64; volRight = 200;
    sendPair(1000001, -1000001);
    check("R1 left scaled", sx(outLeft), expScale(1000001, 64));
    check("R3 right own code", sx(outRight), expScale(-1000001, 200));
    @(negedge clk);
    check("R5 hold left", sx(outLeft), expScale(1000001, 64));
    check("R1 outValid drops", outValid, 0);
    volLeft = 128; volRight = 255;
    sendPair(-3, 24'h7FFFFF);
    check("R1 round toward zero", sx(outLeft), -1);
    check("R1 code 255", sx(outRight), expScale(longint'(24'h7FFFFF), 255));
  endtask

  task automatic testMute();
    volLeft = 0; volRight = 0; muteEn = 1'b1;
    sendPair(777, -777);
    check("R4 mute left", sx(outLeft), 0);
    check("R4 mute right", sx(outRight), 0);
    check("R4 outValid", outValid, 1);
    muteEn = 1'b0;
  endtask

  task automatic testPeak();
    readOnly(1, 1);
    check("R8 left cleared", peakLeft, 0);
    check("R8 right cleared", peakRight, 0);
    sendPair(100, -300);
    sendPair(50, -20);
    check("R6 left peak", peakLeft, 100);
    check("R6 right peak", peakRight, 300);
    sendPair(-8388608, -8388608);
    check("R7 saturate left", peakLeft, 23'h7FFFFF);
    check("R7 saturate right", peakRight, 23'h7FFFFF);
  endtask

  task automatic testReadCoincident();
    sendPair(5, -7, 1, 1);
    check("R9 left loads sample", peakLeft, 5);
    check("R9 right loads sample", peakRight, 7);
    readOnly(1, 0);
    check("R8 left read clears", peakLeft, 0);
    check("R8 right untouched", peakRight, 7);
  endtask

  task automatic testZero();
    sendPair(1, 1);
    for (int i = 0; i < 1023; i++) sendPair(0, 9);
    check("R10 not yet", zeroLeft, 0);
    sendPair(0, 9);
    check("R10 left asserts", zeroLeft, 1);
    check("R10 right stays low", zeroRight, 0);
    sendPair(4, 9);
    check("R11 left clears", zeroLeft, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testUnity();
    testScale();
    testMute();
    testPeak();
    testReadCoincident();
    testZero();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule